// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-port static RAM with 32-bit words, byte-lane writes and a four-beat burst address sequencer. Every input is captured on the rising clock edge. A burst opens on one of two address strobes. The processor strobe always opens a read. The controller strobe opens a read or a write, depending on the write controls. After that, an advance input either steps the burst to its next address or holds it on the current one.

Read data leaves through an output register. The first edge captures the request and the second edge presents the word. There are no tri-state pads. Instead, a data-valid flag marks the cycles in which the bus would be driven. An asynchronous output enable can mask that flag at any time. A separate counter module generates the two low address bits. A mode input selects whether the counter follows a linear (add) order or an interleaved (XOR) order.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held, and after it is released with no read issued, `dout_vld` is 0.
- R2: `pstart_n`=0 with `ce1_n`=0 and the device selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0) opens a read burst at `addr`, whatever the write controls are. The memory is left unchanged.
- R3: `pstart_n`=0 while `ce1_n`=1 has no effect. That cycle is handled as if only `cstart_n` and `step_n` had been sampled, so an open burst continues or holds.
- R4: `cstart_n`=0 while not selected (and not a valid processor start) closes any open burst. No read data follows that cycle, and later cycles with both strobes high produce no data until a new start.
- R5: `cstart_n`=0 with `pstart_n`=1, while selected, opens a burst at `addr`. It is a write when any byte is enabled and a read otherwise. `din` is taken on the same edge.
- R6: With both strobes high, `step_n`=0 and a burst open, the offset count increments. The low two address bits are base+count mod 4 when `seq_ilv`=0 and base XOR count when `seq_ilv`=1. After four beats the sequence wraps within the aligned group of four words, and the upper bits never change.
- R7: With both strobes high, `step_n`=1 and a burst open, the same address is accessed again.
- R8: `wr_all_n`=0 writes all four byte lanes.
- R9: With `wr_all_n`=1 and `wr_byte_n`=0, `lane_n[i]`=0 writes bits 8i+7:8i of `din`, where lane 0 is bits 7:0 and lane 3 is bits 31:24. The other lanes keep their contents.
- R10: With `wr_all_n`=1, and either `wr_byte_n`=1 or `lane_n`=4'hF, the access is a read.
- R11: `oe_n`=1 forces `dout_vld` to 0 at once, without a clock edge. Lowering `oe_n` again restores it in the same cycle.
- R12: Read data appears after the second rising edge that follows the request. `dout_vld` is 1 only in that cycle.
- R13: While a burst is open, cycles with both strobes high ignore the three chip enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External word address |
| din | input | 32 | Write data |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| pstart_n | input | 1 | Processor address strobe, active low |
| cstart_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write qualifier, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| dout | output | 32 | Registered read data |
| dout_vld | output | 1 | Read data driven on the bus |

## Verification
The hardest state to reach from the ports is an open burst in which a processor strobe arrives while the primary enable is high. In that cycle the strobe must fall through to continue or suspend, and a wrong priority shows up only as a wrong address two edges later. The stimulus reaches this state with directed sequences run in the middle of a burst. It then runs a random mix weighted towards continue and suspend cycles, with ignored strobes and deselects mixed in, under both burst orders. A bench model predicts every returned word.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  input  logic          ilv,
  output logic [CW-1:0] cur
);
  logic [CW-1:0] base_q, base_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = load_val;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur = ilv ? (base_q ^ cnt_q) : (base_q + cnt_q);
endmodule

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode
  import sbs_pkg::*;
(
  input  logic  wr_all_n,
  input  logic  wr_byte_n,
  input  lane_t lane_n,
  output lane_t mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = !wr_all_n || (!wr_byte_n && !lane_n[i]);
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lane_t         we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  word_t         wdata,
  output word_t         rdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) store[addr] <= wdata[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata[i*LANE_W +: LANE_W] <= '0;
      else if (re) rdata[i*LANE_W +: LANE_W] <= store[addr];
    end
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   din,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          pstart_n,
  input  logic          cstart_n,
  input  logic          step_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [3:0]    lane_n,
  input  logic          oe_n,
  input  logic          seq_ilv,
  output logic [31:0]   dout,
  output logic          dout_vld
);
  localparam int CW = 2;
  localparam int UW = AW - CW;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic          sel;
  lane_t         wmask;
  logic          ctr_load, ctr_step;
  logic [CW-1:0] ctr_lo;
  logic          act_q, act_d;
  op_e           op_q, op_d;
  lane_t         mask_q, mask_d;
  logic [UW-1:0] upper_q, upper_d;
  word_t         wdata_q;
  logic          vld_q;
  logic [AW-1:0] addr_cur;
  word_t         rdata;

  assign sel = !ce1_n && ce2 && !ce3_n;

  sbs_wr_decode u_wdec (
    .wr_all_n (wr_all_n),
    .wr_byte_n(wr_byte_n),
    .lane_n   (lane_n),
    .mask     (wmask)
  );

  always_comb begin
    ctr_load = 1'b0;
    ctr_step = 1'b0;
    act_d    = act_q;
    op_d     = OP_IDLE;
    mask_d   = '0;
    upper_d  = upper_q;
    if (!pstart_n && !ce1_n) begin
      if (sel) begin
        ctr_load = 1'b1;
        upper_d  = addr[AW-1:CW];
        act_d    = 1'b1;
        op_d     = OP_READ;
      end else begin
        act_d = 1'b0;
      end
    end else if (!cstart_n) begin
      if (sel) begin
        ctr_load = 1'b1;
        upper_d  = addr[AW-1:CW];
        act_d    = 1'b1;
        op_d     = (|wmask) ? OP_WRITE : OP_READ;
        mask_d   = wmask;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      ctr_step = !step_n;
      op_d     = (|wmask) ? OP_WRITE : OP_READ;
      mask_d   = wmask;
    end
  end

  sbs_burst_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (ctr_load),
    .load_val(addr[CW-1:0]),
    .step    (ctr_step),
    .ilv     (seq_ilv),
    .cur     (ctr_lo)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q   <= 1'b0;
      op_q    <= OP_IDLE;
      mask_q  <= '0;
      upper_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      act_q   <= act_d;
      op_q    <= op_d;
      mask_q  <= mask_d;
      upper_q <= upper_d;
      vld_q   <= (op_q == OP_READ);
    end
  end

  always_ff @(posedge clk) begin
    if (op_d == OP_WRITE) wdata_q <= din;
  end

  assign addr_cur = {upper_q, ctr_lo};

  sbs_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   ((op_q == OP_WRITE) ? mask_q : lane_t'('0)),
    .re   (op_q == OP_READ),
    .addr (addr_cur),
    .wdata(wdata_q),
    .rdata(rdata)
  );

  assign dout     = rdata;
  assign dout_vld = vld_q && !oe_n;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          pstart_n,
  input logic          cstart_n,
  input logic          step_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          wr_all_n,
  input logic          seq_ilv,
  input logic          act_q,
  input op_e           op_q,
  input lane_t         mask_q,
  input logic [AW-1:0] addr_cur,
  input logic          dout_vld
);
  logic sel_w;
  assign sel_w = !ce1_n && ce2 && !ce3_n;

  always @(posedge clk) begin
    if (!rst_sync_n) p_reset_quiet_r1: assert (!dout_vld);
  end

  p_pstart_reads_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pstart_n && sel_w) |=> (op_q == OP_READ));

  p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cstart_n && !sel_w) |=> (!act_q && op_q == OP_IDLE));

  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (act_q && pstart_n && cstart_n && !step_n && !seq_ilv) |=>
    (addr_cur == {$past(addr_cur[AW-1:2]), $past(addr_cur[1:0]) + 2'd1}));

  p_suspend_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (act_q && pstart_n && cstart_n && step_n) |=> $stable(addr_cur));

  p_global_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pstart_n && !cstart_n && sel_w && !wr_all_n) |=> (op_q == OP_WRITE && mask_q == '1));

  p_valid_after_read_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dout_vld |-> $past(op_q == OP_READ));
endmodule

bind sync_burst_sram sbs_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .pstart_n  (pstart_n),
  .cstart_n  (cstart_n),
  .step_n    (step_n),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .ce3_n     (ce3_n),
  .wr_all_n  (wr_all_n),
  .seq_ilv   (seq_ilv),
  .act_q     (act_q),
  .op_q      (op_q),
  .mask_q    (mask_q),
  .addr_cur  (addr_cur),
  .dout_vld  (dout_vld)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   din, dout;
  logic          ce1_n, ce2, ce3_n, pstart_n, cstart_n, step_n;
  logic          wr_all_n, wr_byte_n, oe_n, seq_ilv, dout_vld;
  logic [3:0]    lane_n;

  sync_burst_sram #(.DEPTH(1024)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .pstart_n(pstart_n), .cstart_n(cstart_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .oe_n(oe_n),
    .seq_ilv(seq_ilv), .dout(dout), .dout_vld(dout_vld)
  );

  int errors = 0;
  int checks = 0;

  // reference model, addresses kept below 64
  logic [31:0]   mem_m [64];
  bit            m_act = 0;
  logic [AW-3:0] m_up;
  logic [1:0]    m_base, m_cnt;
  int            s1_op = 0;
  logic [AW-1:0] s1_addr;
  logic [3:0]    s1_mask;
  logic [31:0]   s1_data;
  bit            exp_vld = 0;
  logic [31:0]   exp_data;

  function automatic logic [1:0] f_seq(logic [1:0] b, logic [1:0] c, logic ilv);
    return ilv ? (b ^ c) : (b + c);
  endfunction

  function automatic logic [3:0] f_mask(logic gw, logic bwe, logic [3:0] ln);
    if (!gw)  return 4'hF;
    if (!bwe) return ~ln;
    return 4'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drv(input logic ps, input logic cs, input logic sn, input logic c1,
                     input logic c2, input logic c3, input logic gw, input logic bwe,
                     input logic [3:0] ln, input logic [AW-1:0] a, input logic [31:0] d);
    pstart_n = ps; cstart_n = cs; step_n = sn; ce1_n = c1; ce2 = c2; ce3_n = c3;
    wr_all_n = gw; wr_byte_n = bwe; lane_n = ln; addr = a; din = d;
  endtask

  task automatic step(input string req);
    logic          sel;
    logic [3:0]    mk;
    int            nop;
    logic [AW-1:0] na;
    sel = !ce1_n && ce2 && !ce3_n;
    mk  = f_mask(wr_all_n, wr_byte_n, lane_n);
    nop = 0;
    if (!pstart_n && !ce1_n) begin
      if (sel) begin
        m_act = 1; m_up = addr[AW-1:2]; m_base = addr[1:0]; m_cnt = 0; nop = 1;
      end else m_act = 0;
    end else if (!cstart_n) begin
      if (sel) begin
        m_act = 1; m_up = addr[AW-1:2]; m_base = addr[1:0]; m_cnt = 0;
        nop = (mk != 0) ? 2 : 1;
      end else m_act = 0;
    end else if (m_act) begin
      if (!step_n) m_cnt = m_cnt + 2'd1;
      nop = (mk != 0) ? 2 : 1;
    end
    na = {m_up, f_seq(m_base, m_cnt, seq_ilv)};
    @(posedge clk);
    exp_vld = (s1_op == 1);
    if (s1_op == 1) exp_data = mem_m[s1_addr[5:0]];
    if (s1_op == 2)
      for (int l = 0; l < 4; l++)
        if (s1_mask[l]) mem_m[s1_addr[5:0]][l*8 +: 8] = s1_data[l*8 +: 8];
    s1_op = nop; s1_addr = na; s1_mask = mk; s1_data = din;
    @(negedge clk);
    chk(req, {31'd0, dout_vld}, {31'd0, exp_vld && !oe_n});
    if (exp_vld && !oe_n) chk(req, dout, exp_data);
  endtask

  task automatic desel(input string req);
    drv(1, 0, 1, 1, 0, 1, 1, 1, 4'hF, '0, '0);
    step(req);
  endtask

  task automatic pread(input logic [AW-1:0] a, input string req);
    drv(0, 1, 1, 0, 1, 0, 1, 1, 4'hF, a, '0);
    step(req);
  endtask

  task automatic cont(input logic sn, input string req);
    drv(1, 1, sn, 1, 1, 0, 1, 1, 4'hF, '0, '0);
    step(req);
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      int          r;
      logic [AW-1:0] a;
      logic [31:0] d;
      logic        gw, bwe, sn;
      logic [3:0]  ln;
      r = $urandom_range(99); a = AW'($urandom_range(63)); d = $urandom;
      gw = 1'($urandom_range(1)); bwe = 1'($urandom_range(1)); ln = 4'($urandom);
      sn = 1'($urandom_range(1));
      oe_n = ($urandom_range(9) == 0);
      if (r < 15)      drv(0, 1, sn, 0, 1, 0, gw, bwe, ln, a, d);
      else if (r < 35) drv(1, 0, sn, 0, 1, 0, gw, bwe, ln, a, d);
      else if (r < 40) drv(1, 0, sn, 1, 1'($urandom_range(1)), 1, gw, bwe, ln, a, d);
      else if (r < 45) drv(0, 1, sn, 1, 1, 0, gw, bwe, ln, a, d);
      else drv(1, 1, sn, 1'($urandom_range(1)), 1'($urandom_range(1)),
               1'($urandom_range(1)), gw, bwe, ln, a, d);
      step("R6");
    end
    oe_n = 0;
    desel("R4");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; oe_n = 0; seq_ilv = 0;
    drv(1, 1, 1, 1, 0, 1, 1, 1, 4'hF, '0, '0);
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, dout_vld}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", {31'd0, dout_vld}, 32'd0);

    // R8 fill with global writes
    for (int a = 0; a < 64; a++) begin
      drv(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, AW'(a), 32'hA5000000 ^ (a * 32'h01010101));
      step("R8");
    end
    desel("R8");

    // R2 processor start is a read even with write controls low
    drv(0, 1, 1, 0, 1, 0, 0, 0, 4'h0, 10'd5, 32'hDEADBEEF); step("R2");
    desel("R2"); desel("R2");
    pread(10'd5, "R2"); desel("R2"); desel("R2");

    // R12 latency
    pread(10'd9, "R12"); desel("R12"); desel("R12");

    // R9 byte lanes 0 and 2
    drv(1, 0, 1, 0, 1, 0, 1, 0, 4'b1010, 10'd12, 32'h11223344); step("R9");
    pread(10'd12, "R9"); desel("R9"); desel("R9");

    // R10 reads when no byte enabled
    drv(1, 0, 1, 0, 1, 0, 1, 1, 4'h0, 10'd13, 32'h0BADF00D); step("R10");
    drv(1, 0, 1, 0, 1, 0, 1, 0, 4'hF, 10'd14, 32'h0BADF00D); step("R10");
    desel("R10"); desel("R10");
    pread(10'd13, "R10"); pread(10'd14, "R10"); desel("R10"); desel("R10");

    // R5 write burst of four beats
    drv(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, 10'd20, 32'h50000000); step("R5");
    for (int k = 1; k < 4; k++) begin
      drv(1, 1, 0, 1, 1, 0, 0, 1, 4'hF, '0, 32'h50000000 + k); step("R5");
    end
    desel("R5");
    pread(10'd20, "R5");
    for (int k = 0; k < 3; k++) cont(0, "R5");
    desel("R5"); desel("R5");

    // R6 linear wrap from base 2, then interleaved from base 1
    pread(10'd22, "R6");
    for (int k = 0; k < 5; k++) cont(0, "R6");
    desel("R6"); desel("R6");
    seq_ilv = 1; desel("R6");
    pread(10'd29, "R6");
    for (int k = 0; k < 4; k++) cont(0, "R6");
    desel("R6"); desel("R6");
    seq_ilv = 0; desel("R6");

    // R7 suspend
    pread(10'd33, "R7"); cont(0, "R7"); cont(1, "R7"); cont(1, "R7");
    desel("R7"); desel("R7");

    // R3 processor strobe ignored with primary enable high
    pread(10'd40, "R3");
    drv(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 10'd50, '0); step("R3");
    drv(0, 1, 1, 1, 1, 0, 1, 1, 4'hF, 10'd51, '0); step("R3");
    cont(0, "R3"); desel("R3"); desel("R3");

    // R13 chip enables ignored while continuing
    pread(10'd44, "R13");
    drv(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, '0, '0); step("R13");
    drv(1, 1, 0, 1, 0, 1, 0, 1, 4'hF, '0, 32'h13131313); step("R13");
    desel("R13"); pread(10'd46, "R13"); desel("R13"); desel("R13");

    // R4 deselect closes the burst
    pread(10'd48, "R4");
    drv(1, 0, 0, 0, 0, 0, 1, 1, 4'hF, '0, '0); step("R4");
    cont(0, "R4"); cont(0, "R4"); cont(1, "R4");

    // R11 asynchronous output enable
    pread(10'd50, "R11"); desel("R11");
    oe_n = 1; #1 chk("R11", {31'd0, dout_vld}, 32'd0);
    oe_n = 0; #1 chk("R11", {31'd0, dout_vld}, 32'd1);
    pread(10'd51, "R11"); oe_n = 1; desel("R11"); oe_n = 0; desel("R11");

    // random mix, both burst orders
    rand_run(400);
    seq_ilv = 1; desel("R6");
    rand_run(400);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule